// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block manages the power-saving states of an 8-bit microcontroller. Software reaches it through two byte-wide special-function registers on the SFR bus. The first is a power control register. It holds an idle request, a power-down request, two general-purpose flags and one stored-only bit. The second is a system configuration register. Among its stored bits is the enable for waking from power-down on an external pin.

From these registers, the block drives three enables. One gates the CPU clock, one gates the peripheral clocks (timers, serial port, interrupt logic), and one lets the oscillator run. In idle, only the CPU clock stops, and any enabled pending interrupt restarts it. In power-down, all three enables drop. Only a qualified external interrupt pin or the reset input brings the device back. A pin wake first runs a settling count with all enables held low. Each resume is reported by a one-cycle pulse that says whether execution restarts at the reset vector or enters an interrupt service routine, and which pin caused it.

The block runs from an always-on clock of its own and receives the chip's synchronous active-low reset. The CPU core, the interrupt vectoring and the analog oscillator sit outside it.

Top module: `pmc_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the block is in the following state. The power control register (address 87h) reads 00h and the configuration register (address BFh) reads 02h. `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1. `wake_valid` is 1 with `wake_cause` 0, which means a restart from the reset vector. `wake_valid` is 0 from the second cycle after reset.
- R2: In the power control register, bit 7 and bits 3:2 read back as last written. Bits 6:4 and the two request bits (bit 0 idle, bit 1 power-down) always read 0.
- R3: In the configuration register, bits 7, 4, 2, 1 and 0 read back as written and bits 6, 5 and 3 read 0. Any other address reads 00h.
- R4: A write of the power control register in run mode with bit 0 set and bit 1 clear enters idle. From the next cycle, `cpu_clk_en` is 0 while `per_clk_en` and `osc_en` stay 1.
- R5: In idle, `irq_glob_en` together with any bit set in both `irq_pend` and `irq_en` returns to run at the next edge. `wake_valid` then pulses for one cycle with `wake_cause` 1 and `wake_src` 00.
- R6: A write of the power control register in run mode with bit 1 set enters power-down. From the next cycle, all three enables are 0. When bits 0 and 1 are written together, power-down wins.
- R7: In power-down, the external pins `ext_int_n` are active low and pass through a two-flop synchroniser. A pin wakes the block only when `irq_glob_en`, the pin's own enable and configuration bit 4 are all 1. The pin's own enable is `irq_en[0]` for pin 0 and `irq_en[2]` for pin 1. Any other pending interrupt leaves the block in power-down.
- R8: A qualified pin that goes low before edge 1 keeps all enables 0 until edge 3+`STAB_CYCLES`. At that edge all three enables return to 1. In the same cycle `wake_valid` pulses with `wake_cause` 1 and a one-hot `wake_src`: bit 0 for pin 0 and bit 1 for pin 1, with pin 0 taking priority.
- R9: Driving `rst_n` low from any mode restores the state of R1, clearing every stored register bit. This holds even when a wake pin qualifies in the same cycle.
- R10: A mode request written while the block is not in run mode has no effect. For example, a power-down write during idle leaves `osc_en` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on block clock |
| rst_n | input | 1 | Synchronous active-low reset (reset pin) |
| sfr_addr | input | ADDR_W | SFR byte address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` |
| irq_pend | input | NUM_IRQ | Pending interrupt flags |
| irq_en | input | NUM_IRQ | Per-source interrupt enables |
| irq_glob_en | input | 1 | Global interrupt enable |
| ext_int_n | input | 2 | External interrupt pins, active low |
| cpu_clk_en | output | 1 | CPU core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator run enable |
| wake_valid | output | 1 | One-cycle resume report |
| wake_cause | output | 1 | 0 reset vector, 1 interrupt service |
| wake_src | output | 2 | One-hot pin that ended power-down |

## Verification
Two collisions need attention. A single power control write can carry both the idle and the power-down request. A reset can also arrive in the same cycle that a qualified wake pin falls. The bench writes 8Fh and then expects every enable low and a readback of 8Ch. It also lowers `rst_n` and a qualified pin on the same falling edge and then expects a reset-vector report with no pin source. Random interrupt patterns in idle and random pin patterns in power-down are judged against an expected wake condition that the bench computes from the enables.

// File: rtl/pmc_pkg.sv
// Package: shared types for the power mode controller.
// Assumes: SFR data is one byte wide.
package pmc_pkg;

    localparam int SFR_DW = 8;

    // Operating mode of the controller
    typedef enum logic [1:0] {
        MODE_RUN    = 2'd0,
        MODE_IDLE   = 2'd1,
        MODE_PDOWN  = 2'd2,
        MODE_SETTLE = 2'd3
    } pm_mode_t;

    // How execution resumes after a wake
    typedef enum logic {
        CAUSE_RESET = 1'b0,
        CAUSE_IRQ   = 1'b1
    } wake_cause_t;

endpackage

// File: rtl/pmc_sync.sv
// Module: two-flop synchroniser for asynchronous input pins.
// Assumes: the pins rest at RST_VAL, which the flops take in reset.
module pmc_sync #(
    parameter int          WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [WIDTH-1:0] stage1;

    // Two-stage capture of the asynchronous pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

endmodule

// File: rtl/pmc_regs.sv
// Module: power control and configuration registers on the SFR bus.
// The request bits of the power control register are not stored. A write
// that sets them produces a one-cycle strobe and the bits read back as 0.
// Assumes: reads are combinational from sfr_addr.
module pmc_regs
    import pmc_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PCON_ADDR = 8'h87,
    parameter logic [ADDR_W-1:0] SCFG_ADDR = 8'hBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [SFR_DW-1:0] sfr_wdata,
    output logic [SFR_DW-1:0] sfr_rdata,
    output logic              req_idle,
    output logic              req_pdown,
    output logic              pd_wake_en
);

    localparam int               IDLE_BIT    = 0;
    localparam int               PDOWN_BIT   = 1;
    localparam int               WAKE_EN_BIT = 4;
    localparam logic [SFR_DW-1:0] PCON_KEEP  = 8'h8C;
    localparam logic [SFR_DW-1:0] SCFG_KEEP  = 8'h97;
    localparam logic [SFR_DW-1:0] PCON_RST   = 8'h00;
    localparam logic [SFR_DW-1:0] SCFG_RST   = 8'h02;

    logic [SFR_DW-1:0] pcon_q;
    logic [SFR_DW-1:0] scfg_q;
    logic              wr_pcon;
    logic              wr_scfg;

    // Address decode of the write strobe
    always_comb begin
        wr_pcon = sfr_wr && (sfr_addr == PCON_ADDR);
        wr_scfg = sfr_wr && (sfr_addr == SCFG_ADDR);
    end

    // Storage of the kept bits of both registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcon_q <= PCON_RST;
            scfg_q <= SCFG_RST;
        end else begin
            if (wr_pcon) pcon_q <= sfr_wdata & PCON_KEEP;
            if (wr_scfg) scfg_q <= sfr_wdata & SCFG_KEEP;
        end
    end

    // Mode request strobes taken straight from the write
    always_comb begin
        req_idle  = wr_pcon && sfr_wdata[IDLE_BIT];
        req_pdown = wr_pcon && sfr_wdata[PDOWN_BIT];
    end

    assign pd_wake_en = scfg_q[WAKE_EN_BIT];

    // Read multiplexer
    always_comb begin
        if (sfr_addr == PCON_ADDR)      sfr_rdata = pcon_q;
        else if (sfr_addr == SCFG_ADDR) sfr_rdata = scfg_q;
        else                            sfr_rdata = '0;
    end

endmodule

// File: rtl/pmc_fsm.sv
// Module: power mode sequencer. It holds the run, idle, power-down and
// settle modes, the settle counter and the wake report.
// Assumes: STAB_CYCLES >= 1, and the pin inputs are already synchronised.
module pmc_fsm
    import pmc_pkg::*;
#(
    parameter int NUM_IRQ     = 8,
    parameter int STAB_CYCLES = 16,
    parameter int EX0_IDX     = 0,
    parameter int EX1_IDX     = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_idle,
    input  logic               req_pdown,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               irq_glob_en,
    input  logic [1:0]         pin_n_sync,
    input  logic               pd_wake_en,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               osc_en,
    output logic               wake_valid,
    output logic               wake_cause,
    output logic [1:0]         wake_src
);

    localparam int CNT_W = $clog2(STAB_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STAB_CYCLES - 1);

    pm_mode_t         mode_q, mode_nx;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       src_hold;
    logic             idle_wake;
    logic [1:0]       pin_hit;
    logic             pd_wake;
    logic [1:0]       pin_pick;
    logic             settle_done;

    // Wake conditions for idle and for power-down
    always_comb begin
        idle_wake   = irq_glob_en && |(irq_pend & irq_en);
        pin_hit[0]  = !pin_n_sync[0] && irq_en[EX0_IDX];
        pin_hit[1]  = !pin_n_sync[1] && irq_en[EX1_IDX];
        pd_wake     = irq_glob_en && pd_wake_en && |pin_hit;
        pin_pick    = pin_hit[0] ? 2'b01 : (pin_hit[1] ? 2'b10 : 2'b00);
        settle_done = (mode_q == MODE_SETTLE) && (cnt_q == '0);
    end

    // Next-mode selection, with power-down taking priority over idle
    always_comb begin
        mode_nx = mode_q;
        unique case (mode_q)
            MODE_RUN: begin
                if (req_pdown)     mode_nx = MODE_PDOWN;
                else if (req_idle) mode_nx = MODE_IDLE;
            end
            MODE_IDLE:   if (idle_wake)   mode_nx = MODE_RUN;
            MODE_PDOWN:  if (pd_wake)     mode_nx = MODE_SETTLE;
            MODE_SETTLE: if (settle_done) mode_nx = MODE_RUN;
        endcase
    end

    // Mode register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_RUN;
        else        mode_q <= mode_nx;
    end

    // Settle counter and capture of the winning pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            src_hold <= '0;
        end else if (mode_q == MODE_PDOWN && pd_wake) begin
            cnt_q    <= CNT_LOAD;
            src_hold <= pin_pick;
        end else if (mode_q == MODE_SETTLE && cnt_q != '0) begin
            cnt_q    <= cnt_q - 1'b1;
        end
    end

    // Wake report: a reset restart is shown as a pulse out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_valid <= 1'b1;
            wake_cause <= CAUSE_RESET;
            wake_src   <= '0;
        end else begin
            wake_valid <= 1'b0;
            if (mode_q == MODE_IDLE && idle_wake) begin
                wake_valid <= 1'b1;
                wake_cause <= CAUSE_IRQ;
                wake_src   <= '0;
            end else if (settle_done) begin
                wake_valid <= 1'b1;
                wake_cause <= CAUSE_IRQ;
                wake_src   <= src_hold;
            end
        end
    end

    // Clock enables decoded from the mode register
    always_comb begin
        cpu_clk_en = (mode_q == MODE_RUN);
        per_clk_en = (mode_q == MODE_RUN) || (mode_q == MODE_IDLE);
        osc_en     = per_clk_en;
    end

endmodule

// File: rtl/pmc_top.sv
// Module: top level of the power mode controller. It ties the SFR
// registers, the pin synchroniser and the mode sequencer together.
// Assumes: clk keeps running in every mode; rst_n is synchronous.
module pmc_top
    import pmc_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                NUM_IRQ     = 8,
    parameter int                STAB_CYCLES = 16,
    parameter int                EX0_IDX     = 0,
    parameter int                EX1_IDX     = 2,
    parameter logic [ADDR_W-1:0] PCON_ADDR   = 8'h87,
    parameter logic [ADDR_W-1:0] SCFG_ADDR   = 8'hBF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  sfr_addr,
    input  logic               sfr_wr,
    input  logic [7:0]         sfr_wdata,
    output logic [7:0]         sfr_rdata,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               irq_glob_en,
    input  logic [1:0]         ext_int_n,
    output logic               cpu_clk_en,
    output logic               per_clk_en,
    output logic               osc_en,
    output logic               wake_valid,
    output logic               wake_cause,
    output logic [1:0]         wake_src
);

    logic       req_idle;
    logic       req_pdown;
    logic       pd_wake_en;
    logic [1:0] pin_n_sync;

    pmc_regs #(
        .ADDR_W    (ADDR_W),
        .PCON_ADDR (PCON_ADDR),
        .SCFG_ADDR (SCFG_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sfr_addr   (sfr_addr),
        .sfr_wr     (sfr_wr),
        .sfr_wdata  (sfr_wdata),
        .sfr_rdata  (sfr_rdata),
        .req_idle   (req_idle),
        .req_pdown  (req_pdown),
        .pd_wake_en (pd_wake_en)
    );

    pmc_sync #(
        .WIDTH   (2),
        .RST_VAL (2'b11)
    ) u_pin_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_int_n),
        .q_sync  (pin_n_sync)
    );

    pmc_fsm #(
        .NUM_IRQ     (NUM_IRQ),
        .STAB_CYCLES (STAB_CYCLES),
        .EX0_IDX     (EX0_IDX),
        .EX1_IDX     (EX1_IDX)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_idle    (req_idle),
        .req_pdown   (req_pdown),
        .irq_pend    (irq_pend),
        .irq_en      (irq_en),
        .irq_glob_en (irq_glob_en),
        .pin_n_sync  (pin_n_sync),
        .pd_wake_en  (pd_wake_en),
        .cpu_clk_en  (cpu_clk_en),
        .per_clk_en  (per_clk_en),
        .osc_en      (osc_en),
        .wake_valid  (wake_valid),
        .wake_cause  (wake_cause),
        .wake_src    (wake_src)
    );

endmodule

// File: rtl/pmc_checker.sv
// Module: temporal checks for the power mode controller, bound to pmc_top.
// Assumes: it observes ports and the internal wake-enable net only.
module pmc_checker #(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] PCON_ADDR = 8'h87,
    parameter logic [ADDR_W-1:0] SCFG_ADDR = 8'hBF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_wr,
    input logic [7:0]        sfr_wdata,
    input logic [7:0]        sfr_rdata,
    input logic              cpu_clk_en,
    input logic              per_clk_en,
    input logic              osc_en,
    input logic              wake_valid,
    input logic              wake_cause,
    input logic [1:0]        wake_src,
    input logic              pd_wake_en
);

    assert_req_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == PCON_ADDR) |-> (sfr_rdata[1:0] == 2'b00 && sfr_rdata[6:4] == 3'b000));

    assert_cfg_holes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == SCFG_ADDR) |-> ((sfr_rdata & 8'h68) == 8'h00));

    assert_idle_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && sfr_wr && sfr_addr == PCON_ADDR && sfr_wdata[1:0] == 2'b01)
        |=> (!cpu_clk_en && per_clk_en && osc_en));

    assert_irq_wake_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_valid && wake_cause) |-> (cpu_clk_en && !$past(cpu_clk_en)));

    assert_pdown_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && sfr_wr && sfr_addr == PCON_ADDR && sfr_wdata[1])
        |=> (!osc_en && !cpu_clk_en && !per_clk_en));

    assert_osc_off_all_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!cpu_clk_en && !per_clk_en));

    assert_no_wake_unqualified_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !pd_wake_en) |=> !osc_en);

    assert_src_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wake_src));

endmodule

bind pmc_top pmc_checker #(
    .ADDR_W    (ADDR_W),
    .PCON_ADDR (PCON_ADDR),
    .SCFG_ADDR (SCFG_ADDR)
) u_pmc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sfr_addr   (sfr_addr),
    .sfr_wr     (sfr_wr),
    .sfr_wdata  (sfr_wdata),
    .sfr_rdata  (sfr_rdata),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .wake_valid (wake_valid),
    .wake_cause (wake_cause),
    .wake_src   (wake_src),
    .pd_wake_en (pd_wake_en)
);

// File: tb/test_pmc_top.sv
`timescale 1ns/1ps
module test_pmc_top;

    localparam int NIRQ = 8;
    localparam int STAB = 16;
    localparam logic [7:0] A_PCON = 8'h87;
    localparam logic [7:0] A_SCFG = 8'hBF;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [7:0]      sfr_addr;
    logic            sfr_wr;
    logic [7:0]      sfr_wdata;
    logic [7:0]      sfr_rdata;
    logic [NIRQ-1:0] irq_pend;
    logic [NIRQ-1:0] irq_en;
    logic            irq_glob_en;
    logic [1:0]      ext_int_n;
    logic            cpu_clk_en, per_clk_en, osc_en;
    logic            wake_valid, wake_cause;
    logic [1:0]      wake_src;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] m_pcon, m_scfg;

    always #4 clk = ~clk;

    pmc_top #(.NUM_IRQ(NIRQ), .STAB_CYCLES(STAB)) i_pmc_top (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_pend(irq_pend),
        .irq_en(irq_en), .irq_glob_en(irq_glob_en), .ext_int_n(ext_int_n),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .wake_valid(wake_valid), .wake_cause(wake_cause), .wake_src(wake_src)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_addr  = a;
        sfr_wdata = d;
        sfr_wr    = 1'b1;
        tick();
        sfr_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        sfr_addr = a;
        #1;
        chk(req, sfr_rdata, exp);
    endtask

    // Enables packed as {cpu, per, osc}
    function automatic logic [2:0] ens();
        return {cpu_clk_en, per_clk_en, osc_en};
    endfunction

    function automatic logic [1:0] exp_src(input logic [1:0] low_pins);
        return low_pins[0] ? 2'b01 : 2'b10;
    endfunction

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; sfr_addr = '0; sfr_wr = 1'b0; sfr_wdata = '0;
        irq_pend = '0; irq_en = '0; irq_glob_en = 1'b0; ext_int_n = 2'b11;
        @(negedge clk);
        repeat (3) tick();

        // R1: state while reset is held
        chk("R1 enables", ens(), 3'b111);
        chk("R1 wake_valid", wake_valid, 1);
        chk("R1 wake_cause", wake_cause, 0);
        rd_chk("R1 pcon", A_PCON, 8'h00);
        rd_chk("R1 scfg", A_SCFG, 8'h02);
        rst_n = 1'b1;
        chk("R1 first cycle valid", wake_valid, 1);
        tick();
        chk("R1 pulse ends", wake_valid, 0);

        // R2/R3: random register traffic against a bench model
        m_pcon = 8'h00; m_scfg = 8'h02;
        for (int i = 0; i < 40; i++) begin
            logic [7:0] a, d;
            int sel;
            sel = $urandom_range(0, 2);
            d   = 8'($urandom);
            a   = (sel == 0) ? A_PCON : (sel == 1) ? A_SCFG : 8'($urandom_range(0, 127));
            if (a == A_PCON) begin
                d = d & 8'hFC;
                m_pcon = d & 8'h8C;
            end else if (a == A_SCFG) begin
                m_scfg = d & 8'h97;
            end
            sfr_write(a, d);
            rd_chk("R2 pcon readback", A_PCON, m_pcon);
            rd_chk("R3 scfg readback", A_SCFG, m_scfg);
            if (a != A_PCON && a != A_SCFG) rd_chk("R3 other addr", a, 8'h00);
        end

        // R4/R5/R10: idle entry, ignored request, random interrupt wake
        for (int i = 0; i < 20; i++) begin
            logic [NIRQ-1:0] p, e;
            logic g, w;
            irq_pend = '0; irq_en = '0; irq_glob_en = 1'b0;
            sfr_write(A_PCON, m_pcon | 8'h01);
            chk("R4 idle enables", ens(), 3'b011);
            sfr_write(A_PCON, m_pcon | 8'h02);
            chk("R10 pdown ignored in idle", ens(), 3'b011);
            p = NIRQ'($urandom); e = NIRQ'($urandom); g = 1'($urandom);
            w = g && |(p & e);
            irq_pend = p; irq_en = e; irq_glob_en = g;
            tick();
            chk("R5 idle wake cpu", cpu_clk_en, w);
            chk("R5 wake pulse", wake_valid, w);
            if (w) begin
                chk("R5 cause", wake_cause, 1);
                chk("R5 src", wake_src, 0);
            end else begin
                irq_pend = 8'h01; irq_en = 8'h01; irq_glob_en = 1'b1;
                tick();
                chk("R5 directed wake", cpu_clk_en, 1);
            end
            tick();
            chk("R5 single pulse", wake_valid, 0);
        end
        irq_pend = '0; irq_en = '0; irq_glob_en = 1'b0;

        // R6/R2: idle and power-down together, power-down wins
        sfr_write(A_SCFG, 8'h00);
        irq_glob_en = 1'b1; irq_en = 8'hFF; irq_pend = 8'hFF;
        sfr_write(A_PCON, 8'h8F);
        chk("R6 pdown over idle", ens(), 3'b000);
        rd_chk("R2 request bits read zero", A_PCON, 8'h8C);

        // R7: pin without the wake enable bit, pending irqs do not wake
        ext_int_n = 2'b00;
        repeat (STAB + 6) tick();
        chk("R7 unqualified stays down", ens(), 3'b000);

        // R9: reset from power-down
        rst_n = 1'b0;
        tick();
        chk("R9 reset enables", ens(), 3'b111);
        chk("R9 cause reset", {wake_valid, wake_cause}, 2'b10);
        rst_n = 1'b1;
        ext_int_n = 2'b11; irq_pend = '0;
        tick();
        rd_chk("R9 pcon cleared", A_PCON, 8'h00);
        tick();

        // R7: wake enable set but per-source enable missing
        sfr_write(A_SCFG, 8'h10);
        irq_en = 8'hFA; irq_glob_en = 1'b1;
        sfr_write(A_PCON, 8'h02);
        ext_int_n = 2'b00;
        repeat (STAB + 6) tick();
        chk("R7 source enable needed", osc_en, 0);
        irq_en = 8'h05; irq_glob_en = 1'b0;
        repeat (STAB + 6) tick();
        chk("R7 global enable needed", osc_en, 0);
        rst_n = 1'b0; ext_int_n = 2'b11;
        tick();
        rst_n = 1'b1;
        tick();

        // R8: qualified random pins, settle length and source report
        for (int i = 0; i < 8; i++) begin
            logic [1:0] pins;
            int n;
            pins = 2'($urandom_range(1, 3));
            sfr_write(A_SCFG, 8'h10 | (8'($urandom) & 8'h87));
            irq_en = NIRQ'($urandom) | 8'h05; irq_glob_en = 1'b1;
            irq_pend = NIRQ'($urandom);
            sfr_write(A_PCON, 8'h02);
            chk("R6 pdown entry", ens(), 3'b000);
            ext_int_n = ~pins;
            n = 0;
            do begin
                @(posedge clk); n++; @(negedge clk);
            end while (!cpu_clk_en && n < 100);
            chk("R8 settle edges", n, STAB + 3);
            chk("R8 enables back", ens(), 3'b111);
            chk("R8 pulse cause", {wake_valid, wake_cause}, 2'b11);
            chk("R8 src", wake_src, exp_src(pins));
            ext_int_n = 2'b11; irq_pend = '0;
            repeat (3) tick();
        end

        // R9: reset collides with a qualified pin
        sfr_write(A_SCFG, 8'h10);
        irq_en = 8'h05; irq_glob_en = 1'b1;
        sfr_write(A_PCON, 8'h02);
        ext_int_n = 2'b10; rst_n = 1'b0;
        tick();
        chk("R9 reset wins enables", ens(), 3'b111);
        chk("R9 reset wins cause", {wake_valid, wake_cause, wake_src}, 4'b1000);
        tick();
        rst_n = 1'b1; ext_int_n = 2'b11;
        rd_chk("R9 scfg restored", A_SCFG, 8'h02);
        tick();
        chk("R1 pulse ends after reset", wake_valid, 0);

        summary();
        $finish;
    end

endmodule